// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static memory that uses a late-write protocol. On every rising clock edge it registers a command made of a select, a write flag, an address and a set of lane enables. For a read, the stored word comes out of an output register one cycle later. For a write, the data word is taken on the edge *after* the command edge. It then waits in a pending-write buffer and goes into the array when the next write arrives or when the block is put to sleep. A read that hits the address held in the buffer gets that buffered data, merged lane by lane with the array contents. Reads therefore always see the most recent write in command order.

The word is made of 9-bit lanes (8 data bits plus 1 parity bit). A parameter selects one of two organisations: 4 lanes (36 bits) or 2 lanes (18 bits). The depth is a parameter. A sleep input stops new commands from being accepted and keeps the read output quiet. It still lets a buffered write drain into the array, and the array keeps its contents.

The command side has no ready signal and never applies back-pressure: the block accepts a command on every edge. The read side is a valid-qualified stream with no ready either, so the consumer must take each word in the cycle that `rd_valid` is high. `wr_data` is consumed only in the cycle after an accepted write.

Top module: `lw_sram`

## Requirements
- R1: After reset, `rd_valid` is 0 and `rd_data` is all zero.
- R2: A read accepted at edge N (`cmd_valid`=1, `cmd_we`=0, `sleep`=0) sets `rd_valid` for exactly one cycle after edge N+1, with the addressed word on `rd_data`.
- R3: For a write accepted at edge N, the word on `wr_data` at edge N+1 is the one stored. `wr_data` at any other edge has no effect on the memory.
- R4: Lane enable bit b selects bits [9b+8:9b]. Only lanes whose enable was 1 in the write command change, and the other lanes keep their old values.
- R5: A read issued in the cycle right after a write to the same address returns the new data. This is merged with the old contents under that write's lane enables.
- R6: Reads accepted on consecutive edges produce results on consecutive cycles, in command order. This holds across reads and writes that are interleaved.
- R7: When `rd_valid` is 0, `rd_data` is all zero.
- R8: A command presented while `sleep` is 1 is ignored: a read gives no `rd_valid`, and a write does not change memory contents.
- R9: A write that is buffered when `sleep` rises is still committed. The array keeps its contents through any length of sleep and returns them once the block is awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Low-activity mode; blocks new commands |
| cmd_valid | input | 1 | Command select |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_be | input | LANES | Per-lane write enables |
| wr_data | input | LANES*9 | Write word, sampled one edge after its command |
| rd_valid | output | 1 | Read word present on `rd_data` |
| rd_data | output | LANES*9 | Read word, zero when not valid |

## Verification
A read command driven before edge N has its result on `rd_valid`/`rd_data` after edge N+1. The driver pushes the expected word onto the scoreboard queue when it issues the command, and the monitor samples on the falling edge in the cycle the result is due. The write word is driven in the step that follows its command. Every step that is not paired with a write drives a junk pattern, so a mis-timed capture shows up as a mismatch on a later read. The bench samples the sleep windows one cycle at a time for a stray `rd_valid`. An unexpected `rd_valid` on an empty queue counts as a failure.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  localparam int LANE_W = 9;

  function automatic int lanes_for(input bit wide_org);
    return wide_org ? 4 : 2;
  endfunction
endpackage

// File: rtl/lw_cmd_stage.sv
module lw_cmd_stage #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  output logic              s1_rd,
  output logic              s1_wr,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_be
);
  logic take;
  assign take = cmd_valid && !sleep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_rd   <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_be   <= '0;
    end else begin
      s1_rd   <= take && !cmd_we;
      s1_wr   <= take && cmd_we;
      s1_addr <= cmd_addr;
      s1_be   <= cmd_be;
    end
  end

  // R8: a command seen while asleep never reaches the stage
  a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !(s1_rd || s1_wr));
endmodule

// File: rtl/lw_write_buffer.sv
module lw_write_buffer #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              s1_wr,
  input  logic [ADDR_W-1:0] s1_addr,
  input  logic [LANES-1:0]  s1_be,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pend_valid,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [LANES-1:0]  pend_be,
  output logic [WORD_W-1:0] pend_data,
  output logic              commit_en
);
  // Drain the held write when a newer one displaces it or when asleep.
  assign commit_en = pend_valid && (s1_wr || sleep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_be    <= '0;
      pend_data  <= '0;
    end else if (s1_wr) begin
      pend_valid <= 1'b1;
      pend_addr  <= s1_addr;
      pend_be    <= s1_be;
      pend_data  <= wr_data;
    end else if (commit_en) begin
      pend_valid <= 1'b0;
    end
  end

  // R3: the word present one edge after the command is the one held
  a_r3_late_capture: assert property (@(posedge clk) disable iff (!rst_n)
    s1_wr |=> (pend_valid && pend_addr == $past(s1_addr) && pend_data == $past(wr_data)));

  // R9: sleeping with nothing new to buffer empties the buffer
  a_r9_sleep_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && pend_valid && !s1_wr) |=> !pend_valid);
endmodule

// File: rtl/lw_array.sv
module lw_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                                  clk,
  input  logic                                  we,
  input  logic [ADDR_W-1:0]                     waddr,
  input  logic [LANES-1:0]                      wbe,
  input  logic [LANES*lw_sram_pkg::LANE_W-1:0]  wdata,
  input  logic [ADDR_W-1:0]                     raddr,
  output logic [LANES*lw_sram_pkg::LANE_W-1:0]  rdata
);
  localparam int LW    = lw_sram_pkg::LANE_W;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wbe[g]) mem[waddr] <= wdata[g*LW +: LW];
    end
    assign rdata[g*LW +: LW] = mem[raddr];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter bit WIDE_ORG = 1'b1,
  parameter int ADDR_W   = 6,
  localparam int LANES   = lw_sram_pkg::lanes_for(WIDE_ORG),
  localparam int WORD_W  = LANES * lw_sram_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LANES-1:0]  cmd_be,
  input  logic [WORD_W-1:0] wr_data,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int LW = lw_sram_pkg::LANE_W;

  logic              s1_rd, s1_wr;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_be;
  logic              pend_valid, commit_en;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_be;
  logic [WORD_W-1:0] pend_data, arr_rd, fwd_word, rd_q;
  logic              hit;

  lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk, .rst_n, .sleep, .cmd_valid, .cmd_we, .cmd_addr, .cmd_be,
    .s1_rd, .s1_wr, .s1_addr, .s1_be
  );

  lw_write_buffer #(.ADDR_W(ADDR_W), .LANES(LANES), .WORD_W(WORD_W)) u_wbuf (
    .clk, .rst_n, .sleep, .s1_wr, .s1_addr, .s1_be, .wr_data,
    .pend_valid, .pend_addr, .pend_be, .pend_data, .commit_en
  );

  lw_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk, .we(commit_en), .waddr(pend_addr), .wbe(pend_be),
    .wdata(pend_data), .raddr(s1_addr), .rdata(arr_rd)
  );

  // Forward a held write over stale array lanes
  assign hit = pend_valid && (pend_addr == s1_addr);
  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign fwd_word[g*LW +: LW] = (hit && pend_be[g]) ? pend_data[g*LW +: LW]
                                                      : arr_rd[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_q     <= '0;
    end else begin
      rd_valid <= s1_rd;
      if (s1_rd) rd_q <= fwd_word;
    end
  end

  assign rd_data = rd_valid ? rd_q : '0;

  // R2: accepted read surfaces two edges later
  a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_we && !sleep) |=> ##1 rd_valid);

  // R8: nothing read back for a command presented during sleep
  a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !rd_valid) |=> ##1 (!rd_valid || $past(cmd_valid && !cmd_we && !sleep, 1)));

  // R7: idle output is quiet
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> (rd_data == '0));
endmodule

// File: tb/lw_sram_tb.sv
module lw_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int W  = 36;
  localparam logic [W-1:0] JUNK = 36'h5A5A5A5A5;

  logic clk = 1'b0, rst_n = 1'b0, sleep = 1'b0;
  logic cmd_valid = 1'b0, cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [NB-1:0] cmd_be = '0;
  logic [W-1:0] wr_data = JUNK;
  logic rd_valid;
  logic [W-1:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lw_sram #(.WIDE_ORG(1'b1), .ADDR_W(AW)) u_dut (
    .clk, .rst_n, .sleep, .cmd_valid, .cmd_we, .cmd_addr, .cmd_be,
    .wr_data, .rd_valid, .rd_data
  );

  int checks = 0, fails = 0;
  bit done = 1'b0, mon_on = 1'b0;
  logic [W-1:0] model [1<<AW];
  logic [W-1:0] exp_q [$];
  string tag_q [$];
  bit prev_wr = 1'b0;
  logic [W-1:0] prev_d = '0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit we, input logic [AW-1:0] a,
                      input logic [NB-1:0] be, input logic [W-1:0] d,
                      input bit slp, input string tag);
    sleep = slp; cmd_valid = v; cmd_we = we; cmd_addr = a; cmd_be = be;
    wr_data = prev_wr ? prev_d : JUNK;
    if (v && !slp) begin
      if (we) begin
        for (int b = 0; b < NB; b++)
          if (be[b]) model[a][b*9 +: 9] = d[b*9 +: 9];
      end else begin
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
      end
    end
    prev_wr = v && we && !slp;
    prev_d = d;
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit slp);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, '0, slp, "");
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8/R2 unexpected rd_valid", rd_data, '0);
        end else begin
          automatic logic [W-1:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(rd_data === e, t, rd_data, e);
        end
      end else begin
        check(rd_data === '0, "R7 idle data", rd_data, '0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(rd_valid === 1'b0, "R1 rd_valid", {35'b0, rd_valid}, '0);
    check(rd_data === '0, "R1 rd_data", rd_data, '0);
    // Initialise every address used so reads never see unwritten lanes
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b1, i[AW-1:0], 4'hF, {28'h0, i[7:0]}, 1'b0, "");
    idle(2, 1'b0);
    mon_on = 1'b1;

    // R5 read right after write, full word
    step(1'b1, 1'b1, 6'd0, 4'hF, 36'h123456789, 1'b0, "");
    step(1'b1, 1'b0, 6'd0, 4'h0, '0, 1'b0, "R5 forward full");
    step(1'b1, 1'b1, 6'd9, 4'hF, 36'hFEDCBA987, 1'b0, "");
    step(1'b1, 1'b0, 6'd0, 4'h0, '0, 1'b0, "R2 array read");
    idle(3, 1'b0);

    // R6 back-to-back writes then reads
    for (int i = 1; i <= 8; i++)
      step(1'b1, 1'b1, i[AW-1:0], 4'hF, {4'h3, 24'h0, i[7:0]} ^ 36'h0F0F0F0F0, 1'b0, "");
    for (int i = 1; i <= 8; i++)
      step(1'b1, 1'b0, i[AW-1:0], 4'h0, '0, 1'b0, "R6 burst read");
    idle(3, 1'b0);

    // R4 lane writes: forwarded merge, then array merge
    step(1'b1, 1'b1, 6'd1, 4'b0101, 36'hAAAAAAAAA, 1'b0, "");
    step(1'b1, 1'b0, 6'd1, 4'h0, '0, 1'b0, "R4 R5 merged forward");
    step(1'b1, 1'b1, 6'd2, 4'b1000, 36'h1FF000000, 1'b0, "");
    step(1'b1, 1'b1, 6'd3, 4'b0010, 36'h000077E00, 1'b0, "");
    step(1'b1, 1'b0, 6'd1, 4'h0, '0, 1'b0, "R4 lanes from array");
    step(1'b1, 1'b0, 6'd2, 4'h0, '0, 1'b0, "R4 top lane");
    step(1'b1, 1'b0, 6'd3, 4'h0, '0, 1'b0, "R4 R5 lane1 forward");
    idle(3, 1'b0);

    // R3 junk on wr_data outside the data cycle; write then read via interleave
    step(1'b1, 1'b1, 6'd4, 4'hF, 36'h0C0FFEE11, 1'b0, "");
    idle(2, 1'b0);
    step(1'b1, 1'b0, 6'd4, 4'h0, '0, 1'b0, "R3 late data only");
    step(1'b1, 1'b1, 6'd5, 4'hF, 36'h777777777, 1'b0, "");
    step(1'b1, 1'b0, 6'd4, 4'h0, '0, 1'b0, "R3 R6 interleave");
    step(1'b1, 1'b0, 6'd5, 4'h0, '0, 1'b0, "R3 R6 interleave");
    idle(3, 1'b0);

    // R8 commands during sleep are ignored
    step(1'b1, 1'b1, 6'd6, 4'hF, 36'hBADBADBAD, 1'b1, "");
    step(1'b1, 1'b0, 6'd6, 4'h0, '0, 1'b1, "");
    for (int i = 0; i < 4; i++) begin
      check(rd_valid === 1'b0, "R8 no rd_valid asleep", {35'b0, rd_valid}, '0);
      step(1'b1, 1'b0, 6'd7, 4'h0, '0, 1'b1, "");
    end
    idle(2, 1'b0);
    step(1'b1, 1'b0, 6'd6, 4'h0, '0, 1'b0, "R8 write ignored");
    idle(3, 1'b0);

    // R9 buffered write survives sleep
    step(1'b1, 1'b1, 6'd10, 4'b0011, 36'h0000ABCDE, 1'b0, "");
    idle(12, 1'b1);
    idle(1, 1'b0);
    step(1'b1, 1'b0, 6'd10, 4'h0, '0, 1'b0, "R9 kept through sleep");
    step(1'b1, 1'b0, 6'd9, 4'h0, '0, 1'b0, "R9 other word kept");
    idle(4, 1'b0);

    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule